// File: doc/BRIEF.md
# Waveform Compare Timer

This block is one channel of a 16-bit up-counting timer used to generate waveforms. Software programs a compare value and a mode word over a small register bus, then issues clock-enable and start commands. The counter advances by one on each cycle where the `tick` strobe is high. A compare event happens on a tick where the running counter equals the compare value. That event sets a sticky status flag and can raise the interrupt line. Depending on the mode word, it can also reload the counter to zero, halt counting, or switch the counter clock off. It also updates two waveform pins, each with its own set, clear, toggle or hold action.

Control is a three-state machine. In `ST_CLK_OFF` the counter clock is off; this is the reset state. In `ST_STOPPED` the clock is on but the counter is idle. In `ST_COUNTING` the counter runs on ticks. The transitions are:
- `enable` goes from ST_CLK_OFF to ST_STOPPED.
- `enable_start` goes from ST_CLK_OFF to ST_COUNTING.
- `start` goes from ST_STOPPED to ST_COUNTING.
- `restart` goes from ST_COUNTING to ST_COUNTING and clears the counter.
- `halt` goes from ST_COUNTING to ST_STOPPED on a compare event.
- `clock_off` goes from ST_COUNTING to ST_CLK_OFF on a compare event.

Register word addresses are:

| Address | Register | Access |
|---|---|---|
| 0 | command | bit0 = clock enable, bit1 = start |
| 1 | mode | |
| 2 | compare value | |
| 3 | interrupt enable | bit0 |
| 4 | status | bit0 = compare flag, cleared by reading |
| 5 | counter | read only |

Top module: `wavecmp_timer`

## Requirements
- R1: After reset the counter reads 0, the status flag is 0, `irq`, `wave_a` and `wave_b` are low, and the machine is in ST_CLK_OFF, so ticks do not advance the counter.
- R2: In ST_COUNTING the counter increments by one on each `tick` cycle, holds on cycles without `tick`, and wraps from 0xFFFF to 0.
- R3: A compare event is a tick in ST_COUNTING with counter equal to the compare value and no start command in the same cycle. It sets status bit0. A read of address 4 clears the flag, but a compare event in the same cycle wins and the flag stays 1.
- R4: `irq` is high exactly when the status flag and interrupt-enable bit0 are both 1.
- R5: With mode bit0 (reload) set, a compare event loads the counter with 0, and the next tick gives 1.
- R6: With mode bit2 (halt) set and bit1 clear, a compare event moves to ST_STOPPED with the counter held at the compare value (0 if reload is set). A start command then restarts counting from 0.
- R7: With mode bit1 (clock off) set, a compare event moves to ST_CLK_OFF, taking precedence over halt. In that state a start command alone is ignored, and a clock-enable command is needed first.
- R8: On a compare event `wave_a` follows mode bits [4:3]: 00 hold, 01 set, 10 clear, 11 toggle. It never changes at other times.
- R9: On a compare event `wave_b` follows mode bits [6:5] with the same encoding as R8. It never changes at other times.
- R10: Command bit1 (start) clears the counter and enters ST_COUNTING from ST_STOPPED or ST_COUNTING. Command bit0 (clock enable) leaves ST_CLK_OFF. Writing both bits at once from ST_CLK_OFF starts counting at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| tick | input | 1 | counter clock-enable strobe |
| wr_en | input | 1 | register write strobe |
| rd_en | input | 1 | register read strobe |
| addr | input | ADDR_W | register word address |
| wdata | input | DATA_W | write data |
| rdata | output | DATA_W | read data of the addressed register |
| irq | output | 1 | interrupt request |
| wave_a | output | 1 | waveform pin A |
| wave_b | output | 1 | waveform pin B |

## Verification
All 128 mode words are swept: every pin-action pair combined with every mix of reload, halt and clock-off. Compare values cycle through 0 to 4, so a compare at zero (an immediate re-match after reload) is told apart from later compares, and the interrupt enable varies between configurations. Separate runs cover the following:
- command ordering from clock-off, to tell an ignored start from a real one;
- a full 16-bit wrap, to tell wrap-around from saturation;
- a status read landing on the same cycle as a compare event, to confirm that the set wins over the clear.

// File: rtl/wavecmp_pkg.sv
package wavecmp_pkg;

    typedef enum logic [1:0] {
        ST_CLK_OFF  = 2'd0,
        ST_STOPPED  = 2'd1,
        ST_COUNTING = 2'd2
    } tmr_state_e;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'd0,
        ACT_SET    = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_TOGGLE = 2'd3
    } pin_act_e;

    // bit0 reload, bit1 clock off, bit2 halt, [4:3] pin A, [6:5] pin B
    typedef struct packed {
        pin_act_e act_b;
        pin_act_e act_a;
        logic     halt;
        logic     clk_off;
        logic     reload;
    } mode_t;

    localparam int MODE_W   = $bits(mode_t);
    localparam int NUM_PINS = 2;

    localparam int REG_CMD    = 0;
    localparam int REG_MODE   = 1;
    localparam int REG_CMPC   = 2;
    localparam int REG_IEN    = 3;
    localparam int REG_STATUS = 4;
    localparam int REG_COUNT  = 5;

endpackage

// File: rtl/wavecmp_regs.sv
module wavecmp_regs
    import wavecmp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              match,
    output mode_t             mode_o,
    output logic [CNT_W-1:0]  cmpc_o,
    output logic              ien_o,
    output logic              flag_o,
    output logic              start_o,
    output logic              clken_o
);

    localparam logic [ADDR_W-1:0] AD_CMD    = ADDR_W'(REG_CMD);
    localparam logic [ADDR_W-1:0] AD_MODE   = ADDR_W'(REG_MODE);
    localparam logic [ADDR_W-1:0] AD_CMPC   = ADDR_W'(REG_CMPC);
    localparam logic [ADDR_W-1:0] AD_IEN    = ADDR_W'(REG_IEN);
    localparam logic [ADDR_W-1:0] AD_STATUS = ADDR_W'(REG_STATUS);
    localparam logic [ADDR_W-1:0] AD_COUNT  = ADDR_W'(REG_COUNT);

    logic status_rd;

    assign start_o   = wr_en && (addr == AD_CMD) && wdata[1];
    assign clken_o   = wr_en && (addr == AD_CMD) && wdata[0];
    assign status_rd = rd_en && (addr == AD_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o <= '0;
            cmpc_o <= '0;
            ien_o  <= 1'b0;
        end else if (wr_en) begin
            if (addr == AD_MODE) mode_o <= mode_t'(wdata[MODE_W-1:0]);
            if (addr == AD_CMPC) cmpc_o <= wdata[CNT_W-1:0];
            if (addr == AD_IEN)  ien_o  <= wdata[0];
        end
    end

    // a compare event in the same cycle outranks the read-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flag_o <= 1'b0;
        else if (match)     flag_o <= 1'b1;
        else if (status_rd) flag_o <= 1'b0;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            AD_MODE:   rdata = DATA_W'(mode_o);
            AD_CMPC:   rdata = DATA_W'(cmpc_o);
            AD_IEN:    rdata = DATA_W'(ien_o);
            AD_STATUS: rdata = DATA_W'(flag_o);
            AD_COUNT:  rdata = DATA_W'(cnt);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/wavecmp_ctrl.sv
module wavecmp_ctrl
    import wavecmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             clken,
    input  mode_t            mode,
    input  logic [CNT_W-1:0] cmpc,
    output logic [CNT_W-1:0] cnt,
    output logic             match,
    output tmr_state_e       state
);

    tmr_state_e       state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             halting;

    assign match   = tick && !start && (state == ST_COUNTING) && (cnt == cmpc);
    assign halting = mode.clk_off || mode.halt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_CLK_OFF;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        unique case (state)
            ST_CLK_OFF: begin
                if (clken) begin
                    state_d = start ? ST_COUNTING : ST_STOPPED;
                    if (start) cnt_d = '0;
                end
            end
            ST_STOPPED: begin
                if (start) begin
                    state_d = ST_COUNTING;
                    cnt_d   = '0;
                end
            end
            ST_COUNTING: begin
                if (start) begin
                    cnt_d = '0;
                end else if (match) begin
                    if (mode.reload)  cnt_d = '0;
                    else if (halting) cnt_d = cnt;
                    else              cnt_d = cnt + 1'b1;
                    if (mode.clk_off)   state_d = ST_CLK_OFF;
                    else if (mode.halt) state_d = ST_STOPPED;
                end else if (tick) begin
                    cnt_d = cnt + 1'b1;
                end
            end
            default: state_d = ST_CLK_OFF;
        endcase
    end

endmodule

// File: rtl/wavecmp_pin.sv
module wavecmp_pin
    import wavecmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     match,
    input  pin_act_e act,
    output logic     pin
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else if (match) begin
            unique case (act)
                ACT_HOLD:   pin <= pin;
                ACT_SET:    pin <= 1'b1;
                ACT_CLEAR:  pin <= 1'b0;
                ACT_TOGGLE: pin <= ~pin;
                default:    pin <= pin;
            endcase
        end
    end

endmodule

// File: rtl/wavecmp_timer.sv
module wavecmp_timer
    import wavecmp_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              wave_a,
    output logic              wave_b
);

    mode_t            mode_s;
    logic [CNT_W-1:0] cmpc_s;
    logic [CNT_W-1:0] cnt_s;
    logic             ien_s;
    logic             flag_s;
    logic             start_s;
    logic             clken_s;
    logic             match_s;
    tmr_state_e       state_s;
    pin_act_e         acts [NUM_PINS];
    logic [NUM_PINS-1:0] pins;

    wavecmp_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .cnt(cnt_s), .match(match_s),
        .mode_o(mode_s), .cmpc_o(cmpc_s), .ien_o(ien_s), .flag_o(flag_s),
        .start_o(start_s), .clken_o(clken_s)
    );

    wavecmp_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .start(start_s), .clken(clken_s),
        .mode(mode_s), .cmpc(cmpc_s),
        .cnt(cnt_s), .match(match_s), .state(state_s)
    );

    assign acts[0] = mode_s.act_a;
    assign acts[1] = mode_s.act_b;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        wavecmp_pin pin_i (
            .clk(clk), .rst_n(rst_n), .match(match_s),
            .act(acts[g]), .pin(pins[g])
        );
    end

    assign wave_a = pins[0];
    assign wave_b = pins[1];
    assign irq    = flag_s & ien_s;

endmodule

// File: rtl/wavecmp_chk.sv
module wavecmp_chk
    import wavecmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             irq,
    input logic             ien,
    input logic             flag,
    input logic             match,
    input logic             start,
    input tmr_state_e       state,
    input mode_t            mode,
    input logic [CNT_W-1:0] cnt,
    input logic             wave_a,
    input logic             wave_b
);

    // R4
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq);

    // R3
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !start) |=> $stable(cnt));

    // R1
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLK_OFF && !start) |=> $stable(cnt));

    // R5
    reload_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode.reload) |=> (cnt == '0));

    // R6
    halt_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode.halt && !mode.clk_off) |=> (state == ST_STOPPED));

    // R7
    clk_off_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && mode.clk_off) |=> (state == ST_CLK_OFF));

    // R8
    pin_a_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> $stable(wave_a));

    // R9
    pin_b_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> $stable(wave_b));

endmodule

bind wavecmp_timer wavecmp_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .irq(irq), .ien(ien_s),
    .flag(flag_s), .match(match_s), .start(start_s), .state(state_s),
    .mode(mode_s), .cnt(cnt_s), .wave_a(wave_a), .wave_b(wave_b)
);

// File: tb/wavecmp_timer_tb_top.sv
module wavecmp_timer_tb_top;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 16;
    localparam int CNT_MOD = 1 << CNT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              irq, wave_a, wave_b;

    int checks = 0;
    int errors = 0;

    // reference model state, derived from the requirements
    int m_run = 0;      // 0 clock off, 1 stopped, 2 counting
    int m_cnt = 0;
    bit m_flag = 0;
    int m_c = 0;
    int m_mode = 0;
    bit m_ien = 0;
    bit ea = 0;
    bit eb = 0;

    always #5 clk = ~clk;

    wavecmp_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq(irq), .wave_a(wave_a), .wave_b(wave_b)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit act_fn(input int a, input bit cur);
        case (a)
            1:       return 1'b1;
            2:       return 1'b0;
            3:       return ~cur;
            default: return cur;
        endcase
    endfunction

    function automatic void model_tick();
        if (m_run == 2) begin
            if (m_cnt == m_c) begin
                m_flag = 1;
                ea = act_fn((m_mode >> 3) & 3, ea);
                eb = act_fn((m_mode >> 5) & 3, eb);
                if (m_mode & 1)        m_cnt = 0;
                else if (!(m_mode & 6)) m_cnt = (m_cnt + 1) % CNT_MOD;
                if (m_mode & 2)        m_run = 0;
                else if (m_mode & 4)   m_run = 1;
            end else begin
                m_cnt = (m_cnt + 1) % CNT_MOD;
            end
        end
    endfunction

    task automatic bus_write(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = DATA_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 0) begin
            if ((d & 1) && m_run == 0) m_run = 1;
            if ((d & 2) && m_run != 0) begin m_run = 2; m_cnt = 0; end
        end
        if (a == 1) m_mode = d & 127;
        if (a == 2) m_c = d % CNT_MOD;
        if (a == 3) m_ien = d[0];
    endtask

    task automatic bus_read(input int a, output int d);
        @(negedge clk);
        rd_en = 1'b1; addr = ADDR_W'(a);
        #1 d = int'(rdata);
        @(negedge clk);
        rd_en = 1'b0;
        if (a == 4) m_flag = 0;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            model_tick();
        end
    endtask

    task automatic compare_all(input string ctx);
        int d;
        check({ctx, " R8 wave_a"}, int'(wave_a), int'(ea));
        check({ctx, " R9 wave_b"}, int'(wave_b), int'(eb));
        check({ctx, " R4 irq"}, int'(irq), int'(m_flag && m_ien));
        bus_read(5, d);
        check({ctx, " R2 count"}, d, m_cnt);
    endtask

    task automatic status_check(input string ctx);
        int d;
        int e;
        e = int'(m_flag);
        bus_read(4, d);
        check({ctx, " R3 status"}, d, e);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int d;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state, ticks ignored while clock off
        check("R1 wave_a", int'(wave_a), 0);
        check("R1 wave_b", int'(wave_b), 0);
        check("R1 irq", int'(irq), 0);
        status_check("R1 reset");
        do_ticks(3);
        compare_all("R1 clock off");

        // R10 / R7 start alone ignored in clock-off, enable alone does not count
        bus_write(2, 1000);
        bus_write(0, 2);
        do_ticks(2);
        compare_all("R7 start ignored");
        bus_write(0, 1);
        do_ticks(2);
        compare_all("R10 enabled idle");
        bus_write(0, 2);
        do_ticks(3);
        compare_all("R10 started");

        // R2 wrap past 0xFFFF with tick held high
        bus_write(0, 2);
        @(negedge clk); tick = 1'b1;
        for (int i = 0; i < CNT_MOD + 1; i++) begin
            @(negedge clk);
            model_tick();
        end
        tick = 1'b0;
        compare_all("R2 wrap");
        check("R2 wrap value", m_cnt, 1);

        // R3 read-clear and compare event in the same cycle
        bus_write(1, 0);
        bus_write(2, 2);
        bus_read(4, d);
        bus_write(0, 2);
        do_ticks(2);
        @(negedge clk);
        tick = 1'b1; rd_en = 1'b1; addr = ADDR_W'(4);
        @(negedge clk);
        tick = 1'b0; rd_en = 1'b0;
        m_flag = 0;
        model_tick();
        status_check("R3 set wins");
        status_check("R3 cleared");

        // sweep of every mode word (R5 R6 R7 R8 R9)
        for (int m = 0; m < 128; m++) begin
            bus_write(1, m);
            bus_write(2, m % 5);
            bus_write(3, (m % 3 != 0) ? 1 : 0);
            status_check("R3 pre");
            bus_write(0, 3);
            do_ticks(m % 5);
            compare_all("R2 before compare");
            do_ticks(1);
            compare_all("R5 R6 R7 compare");
            do_ticks(1);
            compare_all("R5 R6 R7 after");
            status_check("R3 sticky");
            status_check("R3 clear");
            bus_write(0, 2);
            do_ticks(2);
            compare_all("R6 R7 restart");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule